// File: doc/BRIEF.md
# Dual-Bank Flash Command Decoder

This block is the command front end of a small two-bank NOR flash model. It watches host write cycles and decodes the two-write unlock prefix and the command bytes that follow. Each bank has its own mode register: plain array read, identification query, timed program, fast-program (unlock bypass) and a suspended-erase read mode that test code can preset. Because the modes are held per bank, one bank can be programming while the host reads array data from the other.

Reads go through a combinational mux. A bank in the identification mode answers with a vendor code, a device code or a per-sector protection flag. A bank that is programming answers with a fixed status word. Every other mode returns the stored word. A program operation lasts a fixed number of clock cycles. When it ends, the stored word becomes the old value ANDed with the new one, so programming can only clear bits. A synchronous `rst` initialises the array and every mode. The separate `hw_rst` aborts any program in flight and returns both banks to array read, and it leaves the array contents alone.

Top module: `dbank_cmd_fsm`

## Requirements
- R1: After `rst`, every array word reads FFFFh, both banks are in array read and `bank_busy` is 00.
- R2: A write of AAh to address 555h, then 55h to 2AAh, then A0h, then an address/data write starts a program of that word. The bank number is address bit AW-1 and the word index is the low MEM_AW address bits. Unlock addresses are matched on address bits 10:0 and command codes on data bits 7:0. `bank_busy[bank]` is 1 for exactly PGM_CYC cycles after the data write, and the bank then returns to array read.
- R3: A finished program stores old AND new, so bits that are already 0 stay 0.
- R4: While either bank is busy, every write is ignored. Reads of the idle bank return array data, and reads of the busy bank return 0000h.
- R5: Two unlock writes followed by 90h, written to an address in a bank, put only that bank in identification mode. The other bank keeps returning array data.
- R6: In identification mode, offset 00h (address bits 7:0) returns the vendor code. Offset 01h (with `byte_mode`=0) or 02h (with `byte_mode`=1) returns the device code. These reads can be repeated any number of times.
- R7: In identification mode, offset 02h (with `byte_mode`=0) or 04h (with `byte_mode`=1) returns 0001h if the sector is protected and 0000h if it is not. The sector is address bits AW-2 down to AW-1-SEC_W, and its flag is bit {bank,sector} of PROT.
- R8: A write of F0h returns every bank that is in identification mode to the mode it came from: array read, or suspended-erase read. Banks in other modes are not affected.
- R9: `esus_set[b]` moves bank b from array read to suspended-erase read. That mode returns array data, accepts the identification command, and ignores standard program commands.
- R10: Two unlock writes followed by 20h put a bank in bypass mode. In bypass mode, A0h followed by an address/data write programs a word, and the bank then returns to bypass mode. Any other command, F0h included, is ignored.
- R11: In bypass mode, a write of 90h to the bank followed by a write of 00h returns the bank to array read. After that, a two-write program no longer has any effect.
- R12: Any write that breaks the expected sequence returns the decoder to idle and leaves every bank mode unchanged.
- R13: `hw_rst` aborts a program in flight. `bank_busy` is 00 on the next cycle, the target word is unchanged, and every other stored word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; resets the array and all modes |
| hw_rst | input | 1 | Hardware reset, active high; aborts a program and returns both banks to array read |
| byte_mode | input | 1 | 1 selects byte-mode offsets for identification queries |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Host write address |
| wr_data | input | 16 | Host write data; commands are taken from bits 7:0 |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| esus_set | input | 2 | Per-bank preset into suspended-erase read mode |
| bank_busy | output | 2 | Per-bank program-in-progress flag |

## Verification
The bench builds the block with PGM_CYC=5, so a whole program window fits between a few host writes. This lets it place ignored commands, reads of the other bank and a hardware reset inside the busy interval, and still check the exact cycle on which busy falls. It keeps AW=12, MEM_AW=4 and SEC_W=2, with PROT=24h marking sector 2 of bank 0 and sector 1 of bank 1 as protected. Protection queries in word and byte mode can therefore return both 0001h and 0000h from the same bank.

// File: rtl/dbank_pkg.sv
`timescale 1ns/1ps
package dbank_pkg;

    localparam int NBANK = 2;

    typedef enum logic [2:0] {
        BM_READ, BM_IDQ, BM_PGM, BM_BYP, BM_ESUS
    } bmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGMA, SQ_BYPA, SQ_BYPX
    } seq_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_PGM, ACT_IDQ, ACT_BYP, ACT_BYPX, ACT_IDRST
    } act_e;

    typedef struct packed {
        act_e        kind;
        logic        bank;
        logic [15:0] data;
    } act_t;

    localparam logic [7:0]  CMD_KEY1 = 8'hAA;
    localparam logic [7:0]  CMD_KEY2 = 8'h55;
    localparam logic [7:0]  CMD_PGM  = 8'hA0;
    localparam logic [7:0]  CMD_IDQ  = 8'h90;
    localparam logic [7:0]  CMD_BYP  = 8'h20;
    localparam logic [7:0]  CMD_RST  = 8'hF0;
    localparam logic [7:0]  CMD_BYPX = 8'h00;
    localparam logic [10:0] KEY1_ADDR = 11'h555;
    localparam logic [10:0] KEY2_ADDR = 11'h2AA;

    function automatic logic [15:0] idq_word(
        input logic [7:0]  off,
        input logic        byte_m,
        input logic [15:0] vend,
        input logic [15:0] dev,
        input logic        prot
    );
        logic [7:0] dev_off;
        logic [7:0] prot_off;
        dev_off  = byte_m ? 8'h02 : 8'h01;
        prot_off = byte_m ? 8'h04 : 8'h02;
        if (off == 8'h00)          return vend;
        else if (off == dev_off)   return dev;
        else if (off == prot_off)  return {15'd0, prot};
        else                       return 16'h0000;
    endfunction

endpackage

// File: rtl/dbank_decode.sv
`timescale 1ns/1ps
module dbank_decode
    import dbank_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  bmode_e        bmode [NBANK],
    output act_t          act
);
    seq_e seq_q, seq_d;
    logic cmd_bank_q;
    logic wb;
    logic [7:0] cm;
    logic busy_any;
    logic [AW-1:0] unused_hi;

    assign wb        = wr_addr[AW-1];
    assign cm        = wr_data[7:0];
    assign busy_any  = (bmode[0] == BM_PGM) || (bmode[1] == BM_PGM);
    assign unused_hi = wr_addr;

    always_comb begin
        act.kind = ACT_NONE;
        act.bank = wb;
        act.data = wr_data;
        seq_d    = seq_q;
        if (wr_en && !busy_any) begin
            seq_d = SQ_IDLE;
            if (seq_q == SQ_BYPA) begin
                if (wb == cmd_bank_q && bmode[wb] == BM_BYP) act.kind = ACT_PGM;
            end else if (seq_q == SQ_BYPX) begin
                if (cm == CMD_BYPX) begin
                    act.kind = ACT_BYPX;
                    act.bank = cmd_bank_q;
                end
            end else if (seq_q == SQ_PGMA) begin
                if (bmode[wb] == BM_READ) act.kind = ACT_PGM;
            end else if (bmode[wb] == BM_BYP) begin
                if (cm == CMD_PGM)      seq_d = SQ_BYPA;
                else if (cm == CMD_IDQ) seq_d = SQ_BYPX;
            end else if (cm == CMD_RST) begin
                act.kind = ACT_IDRST;
            end else begin
                case (seq_q)
                    SQ_IDLE: if (wr_addr[10:0] == KEY1_ADDR && cm == CMD_KEY1) seq_d = SQ_UNL1;
                    SQ_UNL1: if (wr_addr[10:0] == KEY2_ADDR && cm == CMD_KEY2) seq_d = SQ_UNL2;
                    SQ_UNL2: begin
                        if (cm == CMD_PGM)
                            seq_d = SQ_PGMA;
                        else if (cm == CMD_IDQ && (bmode[wb] == BM_READ || bmode[wb] == BM_ESUS))
                            act.kind = ACT_IDQ;
                        else if (cm == CMD_BYP && bmode[wb] == BM_READ)
                            act.kind = ACT_BYP;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hw_rst) begin
            seq_q      <= SQ_IDLE;
            cmd_bank_q <= 1'b0;
        end else begin
            seq_q <= seq_d;
            if (seq_d == SQ_BYPA || seq_d == SQ_BYPX) cmd_bank_q <= wb;
        end
    end
endmodule

// File: rtl/dbank_bank.sv
`timescale 1ns/1ps
module dbank_bank
    import dbank_pkg::*;
#(
    parameter bit IDX = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hw_rst,
    input  act_t   act,
    input  logic   esus_set,
    input  logic   pgm_done,
    output bmode_e mode
);
    bmode_e pgm_ret, idq_ret;
    logic   hit;
    logic [15:0] unused_data;

    assign hit         = (act.bank == IDX) && (act.kind != ACT_NONE) && (act.kind != ACT_IDRST);
    assign unused_data = act.data;

    always_ff @(posedge clk) begin
        if (rst || hw_rst) begin
            mode    <= BM_READ;
            pgm_ret <= BM_READ;
            idq_ret <= BM_READ;
        end else if (mode == BM_PGM) begin
            if (pgm_done) mode <= pgm_ret;
        end else if (hit) begin
            case (act.kind)
                ACT_PGM: begin
                    pgm_ret <= (mode == BM_BYP) ? BM_BYP : BM_READ;
                    mode    <= BM_PGM;
                end
                ACT_IDQ: begin
                    idq_ret <= mode;
                    mode    <= BM_IDQ;
                end
                ACT_BYP:  mode <= BM_BYP;
                ACT_BYPX: mode <= BM_READ;
                default: ;
            endcase
        end else if (act.kind == ACT_IDRST && mode == BM_IDQ) begin
            mode <= idq_ret;
        end else if (esus_set && mode == BM_READ) begin
            mode <= BM_ESUS;
        end
    end
endmodule

// File: rtl/dbank_prog.sv
`timescale 1ns/1ps
module dbank_prog
    import dbank_pkg::*;
#(
    parameter int MEM_AW  = 4,
    parameter int PGM_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_rst,
    input  logic              start,
    input  logic              s_bank,
    input  logic [MEM_AW-1:0] s_off,
    input  logic [15:0]       s_data,
    input  logic              r_bank,
    input  logic [MEM_AW-1:0] r_off,
    output logic              done,
    output logic [15:0]       r_word
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int WORDS = NBANK * DEPTH;
    localparam int CW    = $clog2(PGM_CYC + 1);

    logic [15:0]       mem [WORDS];
    logic              run_q;
    logic [CW-1:0]     cnt_q;
    logic [MEM_AW:0]   idx_q;
    logic [15:0]       dat_q;

    assign done   = run_q && (cnt_q == '0);
    assign r_word = mem[{r_bank, r_off}];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
            run_q <= 1'b0;
            cnt_q <= '0;
            idx_q <= '0;
            dat_q <= '0;
        end else if (hw_rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CW'(PGM_CYC - 1);
            idx_q <= {s_bank, s_off};
            dat_q <= s_data;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                mem[idx_q] <= mem[idx_q] & dat_q;
                run_q      <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbank_cmd_fsm.sv
`timescale 1ns/1ps
module dbank_cmd_fsm
    import dbank_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          MEM_AW    = 4,
    parameter int          SEC_W     = 2,
    parameter int          PGM_CYC   = 200,
    parameter logic [15:0] VEND_ID   = 16'h0001,
    parameter logic [15:0] DEV_ID    = 16'h22F6,
    parameter logic [15:0] BUSY_WORD = 16'h0000,
    parameter logic [(NBANK << SEC_W)-1:0] PROT = 8'h24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_rst,
    input  logic          byte_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    input  logic [1:0]    esus_set,
    output logic [1:0]    bank_busy
);
    bmode_e bmode [NBANK];
    act_t   act;
    logic   pgm_done;
    logic [15:0] arr_word;
    logic   rb;
    logic [SEC_W-1:0] rsec;
    logic   unused_rd;

    assign rb        = rd_addr[AW-1];
    assign rsec      = rd_addr[AW-2 -: SEC_W];
    assign unused_rd = ^rd_addr;

    dbank_decode #(.AW(AW)) u_dec (
        .clk(clk), .rst(rst), .hw_rst(hw_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bmode(bmode), .act(act)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        dbank_bank #(.IDX(g[0])) u_bank (
            .clk(clk), .rst(rst), .hw_rst(hw_rst), .act(act),
            .esus_set(esus_set[g]), .pgm_done(pgm_done), .mode(bmode[g])
        );
        assign bank_busy[g] = (bmode[g] == BM_PGM);
    end

    dbank_prog #(.MEM_AW(MEM_AW), .PGM_CYC(PGM_CYC)) u_prog (
        .clk(clk), .rst(rst), .hw_rst(hw_rst),
        .start(act.kind == ACT_PGM), .s_bank(act.bank),
        .s_off(wr_addr[MEM_AW-1:0]), .s_data(act.data),
        .r_bank(rb), .r_off(rd_addr[MEM_AW-1:0]),
        .done(pgm_done), .r_word(arr_word)
    );

    always_comb begin
        case (bmode[rb])
            BM_IDQ:  rd_data = idq_word(rd_addr[7:0], byte_mode, VEND_ID, DEV_ID, PROT[{rb, rsec}]);
            BM_PGM:  rd_data = BUSY_WORD;
            default: rd_data = arr_word;
        endcase
    end
endmodule

// File: rtl/dbank_cmd_fsm_chk.sv
`timescale 1ns/1ps
module dbank_cmd_fsm_chk #(
    parameter int PGM_CYC = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       hw_rst,
    input logic       wr_en,
    input logic [1:0] bank_busy
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)               run_len <= 0;
        else if (|bank_busy)   run_len <= run_len + 1;
        else                   run_len <= 0;
    end

    // R1: reset leaves no bank busy
    p_rst_idle_r1: assert property (@(posedge clk) rst |=> (bank_busy == 2'b00));

    // R2: busy window lasts exactly PGM_CYC cycles unless aborted
    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(|bank_busy) && !$past(hw_rst)) |-> (run_len == PGM_CYC));

    // R2: a program only starts from a host write
    p_start_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(|bank_busy) |-> $past(wr_en));

    // R4: writes during a program are ignored, so never two banks busy
    p_one_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_busy) <= 1);

    // R13: hardware reset ends the program on the next cycle
    p_hw_abort_r13: assert property (@(posedge clk) disable iff (rst)
        hw_rst |=> (bank_busy == 2'b00));
endmodule

bind dbank_cmd_fsm dbank_cmd_fsm_chk #(.PGM_CYC(PGM_CYC)) u_chk (.*);

// File: tb/tb_dbank_cmd_fsm.sv
`timescale 1ns/1ps
module tb_dbank_cmd_fsm;
    localparam int          PGMC = 5;
    localparam logic [15:0] VEND = 16'h0001;
    localparam logic [15:0] DEV  = 16'h22F6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_rst = 1'b0;
    logic        byte_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  esus_set = 2'b00;
    logic [1:0]  bank_busy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    typedef struct {
        bit          is_busy;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    dbank_cmd_fsm #(
        .AW(12), .MEM_AW(4), .SEC_W(2), .PGM_CYC(PGMC),
        .VEND_ID(VEND), .DEV_ID(DEV), .BUSY_WORD(16'h0000), .PROT(8'h24)
    ) dut (
        .clk(clk), .rst(rst), .hw_rst(hw_rst), .byte_mode(byte_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .esus_set(esus_set), .bank_busy(bank_busy)
    );

    // monitor: pop expected items and compare
    initial begin
        forever begin
            item_t it;
            logic [15:0] got;
            wait (sb.size() > 0);
            #0.2;
            it  = sb.pop_front();
            got = it.is_busy ? {14'd0, bank_busy} : rd_data;
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic chk_rd(input logic [11:0] a, input logic [15:0] e, input string tag);
        item_t it;
        rd_addr = a;
        it.is_busy = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic chk_busy(input logic [1:0] e, input string tag);
        item_t it;
        it.is_busy = 1'b1; it.exp = {14'd0, e}; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic std_pgm_nowait(input logic [11:0] a, input logic [15:0] d);
        unlock();
        wr(12'h555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (PGMC * 0 + 100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1
        chk_rd(12'h003, 16'hFFFF, "R1 bank0 erased");
        chk_rd(12'h805, 16'hFFFF, "R1 bank1 erased");
        chk_busy(2'b00, "R1 idle after reset");

        // R2 / R4: standard program, commands ignored while busy
        std_pgm_nowait(12'h003, 16'h12F0);
        chk_busy(2'b01, "R2 busy right after data write");
        chk_rd(12'h805, 16'hFFFF, "R4 other bank reads array");
        chk_rd(12'h003, 16'h0000, "R4 busy bank status word");
        unlock();
        wr(12'h555, 16'h0090);
        chk_busy(2'b01, "R2 still busy at last cycle");
        idle(2);
        chk_busy(2'b00, "R2 busy ends after PGM_CYC");
        chk_rd(12'h003, 16'h12F0, "R2 programmed word");
        chk_rd(12'h000, 16'hFFFF, "R4 write during busy ignored");

        // R3: bits only clear
        std_pgm_nowait(12'h003, 16'h0F0F);
        idle(PGMC);
        chk_rd(12'h003, 16'h0200, "R3 old AND new");

        // R5 / R6 / R7: identification mode on bank 1
        unlock();
        wr(12'h800, 16'h0090);
        chk_rd(12'h800, VEND, "R5 vendor code");
        chk_rd(12'h003, 16'h0200, "R5 bank0 still array");
        chk_rd(12'h801, DEV, "R6 device word mode");
        chk_rd(12'h801, DEV, "R6 repeat device read");
        chk_rd(12'h800, VEND, "R6 repeat vendor read");
        idle(1);
        chk_rd(12'hA02, 16'h0001, "R7 word protected sector");
        chk_rd(12'h802, 16'h0000, "R7 word unprotected sector");
        byte_mode = 1'b1;
        chk_rd(12'h802, DEV, "R6 device byte mode");
        chk_rd(12'hA04, 16'h0001, "R7 byte protected sector");
        chk_rd(12'hC04, 16'h0000, "R7 byte unprotected sector");
        byte_mode = 1'b0;
        idle(1);
        // R8
        wr(12'h000, 16'h00F0);
        chk_rd(12'h800, 16'hFFFF, "R8 reset back to array");

        // R9: suspended-erase read mode on bank 1
        esus_set = 2'b10;
        idle(1);
        esus_set = 2'b00;
        chk_rd(12'h805, 16'hFFFF, "R9 esus reads array");
        std_pgm_nowait(12'h805, 16'h0000);
        chk_busy(2'b00, "R9 program ignored in esus");
        unlock();
        wr(12'h800, 16'h0090);
        chk_rd(12'h800, VEND, "R9 id query from esus");
        wr(12'h000, 16'h00F0);
        chk_rd(12'h800, 16'hFFFF, "R8 leave id query");
        std_pgm_nowait(12'h805, 16'h0000);
        chk_busy(2'b00, "R8 returned to esus not read");
        chk_rd(12'h805, 16'hFFFF, "R8 esus word untouched");
        hw_rst = 1'b1;
        idle(1);
        hw_rst = 1'b0;
        std_pgm_nowait(12'h805, 16'h0F00);
        chk_busy(2'b10, "R13 bank1 read after hw reset");
        chk_rd(12'h003, 16'h0200, "R4 bank0 read during bank1 program");
        idle(PGMC);
        chk_rd(12'h805, 16'h0F00, "R2 bank1 program");

        // R10: bypass mode on bank 0
        unlock();
        wr(12'h555, 16'h0020);
        wr(12'h000, 16'h00A0);
        wr(12'h007, 16'h00FF);
        chk_busy(2'b01, "R10 bypass program busy");
        idle(PGMC);
        chk_rd(12'h007, 16'h00FF, "R10 bypass program result");
        wr(12'h000, 16'h00F0);
        wr(12'h000, 16'h00A0);
        wr(12'h009, 16'h1234);
        idle(PGMC);
        chk_rd(12'h009, 16'h1234, "R10 still bypass after program and F0");

        // R11: leave bypass
        wr(12'h000, 16'h0090);
        wr(12'h123, 16'h0000);
        wr(12'h000, 16'h00A0);
        wr(12'h00A, 16'h0000);
        chk_busy(2'b00, "R11 two-write program gone");
        chk_rd(12'h00A, 16'hFFFF, "R11 word untouched");
        std_pgm_nowait(12'h00A, 16'h5555);
        idle(PGMC);
        chk_rd(12'h00A, 16'h5555, "R11 standard program after exit");

        // R12: broken sequences
        wr(12'h555, 16'h00AA);
        wr(12'h123, 16'h0055);
        wr(12'h555, 16'h00A0);
        wr(12'h00B, 16'h0000);
        chk_busy(2'b00, "R12 bad second address");
        chk_rd(12'h00B, 16'hFFFF, "R12 word untouched");
        unlock();
        wr(12'h555, 16'h0077);
        wr(12'h00C, 16'h0000);
        chk_rd(12'h00C, 16'hFFFF, "R12 bad command code");
        chk_rd(12'h000, 16'hFFFF, "R12 no mode change");

        // R13: hardware reset aborts
        std_pgm_nowait(12'h00D, 16'h0000);
        idle(2);
        chk_busy(2'b01, "R13 busy before abort");
        hw_rst = 1'b1;
        idle(1);
        hw_rst = 1'b0;
        chk_busy(2'b00, "R13 busy cleared");
        chk_rd(12'h00D, 16'hFFFF, "R13 target unchanged");
        chk_rd(12'h003, 16'h0200, "R13 bank0 kept");
        chk_rd(12'h805, 16'h0F00, "R13 bank1 kept");
        std_pgm_nowait(12'h00D, 16'h00F0);
        idle(PGMC);
        chk_rd(12'h00D, 16'h00F0, "R13 program after abort");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule